// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

A single timer channel built around a 16-bit down-counter that steps once per clock. A mode code, written together with a number-format select, picks one of six waveforms for the output pin:
- a level that rises when the count runs out;
- a gate-triggered one-shot;
- a divide-by-N rate pulse;
- a square wave;
- a software-started strobe;
- a gate-started strobe.

The count can run as plain 16-bit binary or as four decimal decades. A loaded value of zero gives the longest period: 65536 clocks in binary, 10000 in decimal.

The block sits behind a host interface that assembles the count bytes and issues the commands. That host interface is not part of this block.
- When a new count is complete, the host pulses a load strobe with the value.
- While a multi-byte rewrite is in progress, the host holds a hold line high.
- The live count and the waveform pin are visible at the ports at all times.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset, the mode is 0, `wave_out` is 0 and `count_now` is 0.
- R2: A loaded value of 0 behaves as 65536 in binary: in mode 0 the output rises 65536 clocks after the load edge.
- R3: In mode 0, `cfg_wr` drives the output low. After a load of N, the output rises exactly N clocks after the load edge (the clock at which the count reaches 0) and stays high until the next configuration or load. Counting continues past zero, so 0 is followed by FFFFh.
- R4: In mode 0, the count is frozen while `cnt_hold` is 1 and resumes when it returns to 0.
- R5: In mode 2 with N >= 2, the output is low for exactly one clock every N clocks. The first low clock is N-1 clocks after the load edge.
- R6: In mode 3 with N >= 2, the output is high for ceil(N/2) clocks, then low for floor(N/2) clocks, repeating. This mode always counts in binary.
- R7: In mode 4, the output is high after configuration. N clocks after the load edge it goes low for exactly one clock, then returns high.
- R8: In mode 1, a load alone changes neither the output nor the count. A rising gate edge reloads the count and drives the output low for N clocks. A new rising edge during that time restarts the N-clock window.
- R9: In mode 5, a rising gate edge after a load reloads the count. N clocks after the edge the output goes low for exactly one clock.
- R10: With `cfg_bcd` = 1, each nibble is a decimal digit (bits 3:0 units, up to bits 15:12 thousands). 0000 steps to 9999, 0100 steps to 0099, and a load of 0010h lasts ten clocks.
- R11: In modes 0, 2, 3 and 4, the count holds while `gate` is 0.
- R12: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock; the count steps on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration strobe: takes `cfg_mode` and `cfg_bcd`, stops counting, sets the idle output level |
| cfg_mode | input | 3 | Mode code 0 to 7 |
| cfg_bcd | input | 1 | 1 selects four-decade decimal counting |
| cnt_hold | input | 1 | A count rewrite is in progress; freezes counting in mode 0 |
| cnt_load | input | 1 | Load-complete strobe for `cnt_value` |
| cnt_value | input | 16 | New count value |
| gate | input | 1 | Count enable (modes 0, 2, 3, 4) or trigger (modes 1, 5) |
| wave_out | output | 1 | Waveform output |
| count_now | output | 16 | Live count register |

## Verification
A wrong count register shows up at the pin within one period: the next edge of `wave_out` lands early or late, and `count_now` differs on the very next clock. Phase or armed-flag errors show as a strobe that lasts more than one clock, a strobe that never ends, or a one-shot that fires without a gate edge. The bench therefore times both output edges of each waveform to the exact clock. It also reads the count at the clock after wrap, hold and gate-pause events.

// File: rtl/tmr_pkg.sv
// Shared types and helpers for the timer channel.
// Assumes: mode codes are three bits wide, and codes 6 and 7 alias the rate and square modes.
package tmr_pkg;

    typedef enum logic [2:0] {
        MODE_TC       = 3'd0,
        MODE_ONESHOT  = 3'd1,
        MODE_RATE     = 3'd2,
        MODE_SQUARE   = 3'd3,
        MODE_SWSTROBE = 3'd4,
        MODE_HWSTROBE = 3'd5
    } tmr_mode_e;

    // Folds codes 6 and 7 onto 2 and 3.
    function automatic tmr_mode_e norm_mode(input logic [2:0] code);
        if (code[2] && code[1])
            return tmr_mode_e'({1'b0, code[1:0]});
        return tmr_mode_e'(code);
    endfunction

endpackage

// File: rtl/tmr_dec.sv
// Combinational one-step decrement of the count.
// Binary: wraps 0 to all ones. Decimal: each nibble is a digit, borrows ripple
// upward, and all zeros wraps to all nines.
// Assumes W is a multiple of 4.
module tmr_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic         bcd,
    output logic [W-1:0] result
);
    localparam int DIGITS = W / 4;

    logic [DIGITS-1:0] borrow;
    logic [DIGITS-1:0] in_ok;
    logic [DIGITS-1:0] out_ok;
    logic [W-1:0]      bcd_res;

    assign borrow[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d;
        assign d = value[4*i +: 4];
        // One decade: borrow taken here turns 0 into 9.
        assign bcd_res[4*i +: 4] = !borrow[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
        assign in_ok[i]  = (d <= 4'd9);
        assign out_ok[i] = (bcd_res[4*i +: 4] <= 4'd9);
        if (i < DIGITS - 1) begin : g_borrow
            assign borrow[i+1] = borrow[i] && (d == 4'd0);
        end
    end

    assign result = bcd ? bcd_res : (value - W'(1));

    // Valid decimal input must give valid decimal output.
    always_comb begin
        if (bcd && (&in_ok)) begin
            assert_bcd_digits_R10: assert (&out_ok)
                else $error("decimal decrement produced a non-decimal digit");
        end
    end

endmodule

// File: rtl/tmr_half_split.sv
// Splits a period N into the high and low half lengths of the square wave.
// High = ceil(N/2), low = floor(N/2); N = 0 stands for 2^W.
// Assumes N >= 2 when used.
module tmr_half_split #(
    parameter int W = 16
) (
    input  logic [W-1:0] n,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic [W:0] n_ext;

    assign n_ext = {(n == '0), n};
    assign lo    = n_ext[W:1];
    assign hi    = n_ext[W:1] + W'(n_ext[0]);

endmodule

// File: rtl/tmr_gate_edge.sv
// Registers the gate and flags a low-to-high transition.
// Assumes gate is already synchronous to clk. The stored level resets high,
// so a gate that is already high when reset ends is not taken as an edge.
module tmr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    // Keeps last cycle's gate level.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate;
    end

    assign rise = gate && !gate_q;

endmodule

// File: rtl/tmr_channel.sv
// One programmable down-counter timer channel with six output modes.
// Holds the count, the reload value, the mode, the armed and running flags and
// the output level. Configuration outranks load, and load outranks counting.
// Assumes: inputs are synchronous to clk; in modes 2 and 3 the loaded N is >= 2;
// mode 3 ignores the decimal select.
module tmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_bcd,
    input  logic             cnt_hold,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             gate,
    output logic             wave_out,
    output logic [CNT_W-1:0] count_now
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_n, reload_q, reload_n;
    tmr_mode_e        mode_q, mode_n;
    logic             bcd_q, bcd_n, armed_q, armed_n, run_q, run_n, out_q, out_n;

    logic [CNT_W-1:0] dec_val, half_src, half_hi, half_lo;
    logic             dec_zero, gate_rise, use_bcd;

    assign use_bcd  = bcd_q && (mode_q != MODE_SQUARE);
    assign half_src = cnt_load ? cnt_value : reload_q;
    assign dec_zero = (dec_val == '0);

    tmr_dec #(.W(CNT_W)) u_dec (
        .value  (cnt_q),
        .bcd    (use_bcd),
        .result (dec_val)
    );

    tmr_half_split #(.W(CNT_W)) u_half (
        .n  (half_src),
        .hi (half_hi),
        .lo (half_lo)
    );

    tmr_gate_edge u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (gate_rise)
    );

    // Next-state selection: configuration, then load, then the mode's count step.
    always_comb begin
        cnt_n    = cnt_q;
        reload_n = reload_q;
        mode_n   = mode_q;
        bcd_n    = bcd_q;
        armed_n  = armed_q;
        run_n    = run_q;
        out_n    = out_q;
        if (cfg_wr) begin
            mode_n  = norm_mode(cfg_mode);
            bcd_n   = cfg_bcd;
            armed_n = 1'b0;
            run_n   = 1'b0;
            out_n   = (norm_mode(cfg_mode) != MODE_TC);
        end else if (cnt_load) begin
            reload_n = cnt_value;
            armed_n  = 1'b1;
            case (mode_q)
                MODE_TC:       begin cnt_n = cnt_value; out_n = 1'b0; run_n = 1'b1; end
                MODE_RATE,
                MODE_SWSTROBE: begin cnt_n = cnt_value; out_n = 1'b1; run_n = 1'b1; end
                MODE_SQUARE:   begin cnt_n = half_hi;   out_n = 1'b1; run_n = 1'b1; end
                MODE_HWSTROBE: out_n = 1'b1;
                default:       ;
            endcase
        end else begin
            case (mode_q)
                MODE_TC: begin
                    if (run_q && gate && !cnt_hold) begin
                        cnt_n = dec_val;
                        if (dec_zero) out_n = 1'b1;
                    end
                end
                MODE_ONESHOT: begin
                    if (gate_rise && armed_q) begin
                        cnt_n = reload_q;
                        out_n = 1'b0;
                        run_n = 1'b1;
                    end else if (run_q) begin
                        cnt_n = dec_val;
                        if (dec_zero) begin
                            out_n = 1'b1;
                            run_n = 1'b0;
                        end
                    end
                end
                MODE_RATE: begin
                    if (run_q && gate) begin
                        cnt_n = (cnt_q == ONE) ? reload_q : dec_val;
                        out_n = (cnt_n != ONE);
                    end
                end
                MODE_SQUARE: begin
                    if (run_q && gate) begin
                        if (cnt_q == ONE) begin
                            out_n = !out_q;
                            cnt_n = out_q ? half_lo : half_hi;
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                end
                MODE_SWSTROBE: begin
                    if (!out_q) out_n = 1'b1;
                    if (run_q && gate) begin
                        cnt_n = dec_val;
                        if (armed_q && dec_zero) begin
                            out_n   = 1'b0;
                            armed_n = 1'b0;
                        end
                    end
                end
                MODE_HWSTROBE: begin
                    if (!out_q) out_n = 1'b1;
                    if (gate_rise && armed_q) begin
                        cnt_n = reload_q;
                        run_n = 1'b1;
                    end else if (run_q) begin
                        cnt_n = dec_val;
                        if (dec_zero) begin
                            out_n = 1'b0;
                            run_n = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            mode_q   <= MODE_TC;
            bcd_q    <= 1'b0;
            armed_q  <= 1'b0;
            run_q    <= 1'b0;
            out_q    <= 1'b0;
        end else begin
            cnt_q    <= cnt_n;
            reload_q <= reload_n;
            mode_q   <= mode_n;
            bcd_q    <= bcd_n;
            armed_q  <= armed_n;
            run_q    <= run_n;
            out_q    <= out_n;
        end
    end

    assign wave_out  = out_q;
    assign count_now = cnt_q;

    // Mode 0: once high, the output stays high until reconfigured or reloaded.
    assert_tc_stays_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TC && out_q && !cfg_wr && !cnt_load) |=> wave_out);

    // Mode 2: the low pulse never lasts past one clock while counting is enabled.
    assert_rate_pulse_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RATE && !out_q && gate && reload_q != ONE && !cfg_wr && !cnt_load)
        |=> wave_out);

    // Mode 3: the output changes only where a half period ends.
    assert_square_toggle_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SQUARE && run_q && gate && cnt_q != ONE && !cfg_wr && !cnt_load)
        |=> $stable(wave_out));

    // Mode 4: the strobe is one clock wide.
    assert_sw_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SWSTROBE && !out_q && !cfg_wr) |=> wave_out);

    // Mode 5: the strobe is one clock wide.
    assert_hw_strobe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HWSTROBE && !out_q && !cfg_wr) |=> wave_out);

endmodule

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
// Self-checking bench for tmr_channel: a vector table of mode waveforms, then
// directed tests for reset, zero load, wrap, hold, gate pause, retrigger and decimal wrap.
module tmr_channel_test;

    typedef struct packed {
        logic [2:0]  mode;
        logic        bcd;
        logic [15:0] val;
        logic [16:0] exp_first;  // negedges after the start edge until the output first changes
        logic [7:0]  exp_len;    // clocks the new level lasts; 0 = not checked
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 16'd5,      17'd6,   8'd0, 4'd3},   // R3
        '{3'd0, 1'b1, 16'h0010,   17'd11,  8'd0, 4'd10},  // R10
        '{3'd2, 1'b0, 16'd4,      17'd4,   8'd1, 4'd5},   // R5
        '{3'd2, 1'b0, 16'd7,      17'd7,   8'd1, 4'd5},   // R5
        '{3'd2, 1'b1, 16'h0012,   17'd12,  8'd1, 4'd10},  // R10
        '{3'd3, 1'b0, 16'd5,      17'd4,   8'd2, 4'd6},   // R6
        '{3'd3, 1'b0, 16'd4,      17'd3,   8'd2, 4'd6},   // R6
        '{3'd3, 1'b0, 16'd9,      17'd6,   8'd4, 4'd6},   // R6
        '{3'd4, 1'b0, 16'd3,      17'd4,   8'd1, 4'd7},   // R7
        '{3'd4, 1'b1, 16'h0100,   17'd101, 8'd1, 4'd10},  // R10
        '{3'd1, 1'b0, 16'd3,      17'd1,   8'd3, 4'd8},   // R8
        '{3'd5, 1'b0, 16'd3,      17'd4,   8'd1, 4'd9},   // R9
        '{3'd6, 1'b0, 16'd4,      17'd4,   8'd1, 4'd12},  // R12
        '{3'd7, 1'b0, 16'd5,      17'd4,   8'd2, 4'd12}   // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_bcd = 1'b0;
    logic        cnt_hold = 1'b0;
    logic        cnt_load = 1'b0;
    logic [15:0] cnt_value = 16'd0;
    logic        gate = 1'b0;
    logic        wave_out;
    logic [15:0] count_now;

    int checks = 0;
    int fails  = 0;

    tmr_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .cfg_bcd   (cfg_bcd),
        .cnt_hold  (cnt_hold),
        .cnt_load  (cnt_load),
        .cnt_value (cnt_value),
        .gate      (gate),
        .wave_out  (wave_out),
        .count_now (count_now)
    );

    always #10 clk = ~clk;

    // Records one check and reports a failure.
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Writes a mode at the next negedge and returns at the negedge after it.
    task automatic setup(input logic [2:0] m, input logic b, input logic g);
        @(negedge clk);
        gate = g; cfg_wr = 1'b1; cfg_mode = m; cfg_bcd = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Runs one vector and times the first two output changes after the start edge.
    task automatic run_vec(input vec_t v, input int limit);
        logic gated;
        logic prev;
        int   first_k;
        int   len;
        gated = (v.mode == 3'd1) || (v.mode == 3'd5);
        setup(v.mode, v.bcd, !gated);
        cnt_load = 1'b1; cnt_value = v.val;
        if (gated) begin
            @(negedge clk);
            cnt_load = 1'b0; gate = 1'b1;
        end
        prev = wave_out;
        first_k = 0; len = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            cnt_load = 1'b0;
            if (wave_out !== prev) begin
                prev = wave_out;
                if (first_k == 0) begin
                    first_k = k;
                    if (v.exp_len == 0) break;
                end else begin
                    len = k - first_k;
                    break;
                end
            end
        end
        check(first_k == int'(v.exp_first), $sformatf("R%0d", v.req),
              $sformatf("mode %0d value %0h first edge", v.mode, v.val), first_k, v.exp_first);
        if (v.exp_len != 0)
            check(len == int'(v.exp_len), $sformatf("R%0d", v.req),
                  $sformatf("mode %0d value %0h level length", v.mode, v.val), len, v.exp_len);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] held;

        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wave_out == 1'b0, "R1", "output after reset", wave_out, 0);
        check(count_now == 16'd0, "R1", "count after reset", count_now, 0);

        // Vector table.
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 300);

        // R3: mode 0 count wraps past zero with the output still high.
        setup(3'd0, 1'b0, 1'b1);
        check(wave_out == 1'b0, "R3", "mode 0 output after configuration", wave_out, 0);
        cnt_load = 1'b1; cnt_value = 16'd2;
        @(negedge clk); cnt_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(count_now == 16'd0 && wave_out, "R3", "count at terminal", count_now, 0);
        @(negedge clk);
        check(count_now == 16'hFFFF, "R3", "count after wrap", count_now, 16'hFFFF);
        check(wave_out == 1'b1, "R3", "output stays high after wrap", wave_out, 1);

        // R4: hold freezes mode 0 counting.
        setup(3'd0, 1'b0, 1'b1);
        cnt_load = 1'b1; cnt_value = 16'd10;
        @(negedge clk); cnt_load = 1'b0; cnt_hold = 1'b1;
        repeat (5) @(negedge clk);
        check(count_now == 16'd10, "R4", "count during hold", count_now, 10);
        cnt_hold = 1'b0;
        @(negedge clk);
        check(count_now == 16'd9, "R4", "count after hold released", count_now, 9);

        // R11: gate low pauses mode 4.
        setup(3'd4, 1'b0, 1'b1);
        cnt_load = 1'b1; cnt_value = 16'd3;
        @(negedge clk); cnt_load = 1'b0; gate = 1'b0;
        repeat (3) @(negedge clk);
        check(count_now == 16'd3, "R11", "count with gate low", count_now, 3);
        gate = 1'b1;
        repeat (2) @(negedge clk);
        check(wave_out == 1'b1, "R11", "no strobe before paused count ends", wave_out, 1);
        @(negedge clk);
        check(wave_out == 1'b0, "R11", "strobe delayed by pause", wave_out, 0);

        // R8: load alone does nothing in mode 1; a retrigger restarts the window.
        setup(3'd1, 1'b0, 1'b0);
        held = count_now;
        cnt_load = 1'b1; cnt_value = 16'd6;
        @(negedge clk); cnt_load = 1'b0;
        repeat (4) @(negedge clk);
        check(wave_out == 1'b1, "R8", "output after load without gate", wave_out, 1);
        check(count_now == held, "R8", "count after load without gate", count_now, held);
        gate = 1'b1;
        @(negedge clk);
        check(wave_out == 1'b0, "R8", "output after trigger", wave_out, 0);
        @(negedge clk); gate = 1'b0;
        @(negedge clk); gate = 1'b1;
        repeat (4) @(negedge clk);
        check(wave_out == 1'b0, "R8", "output still low after retrigger", wave_out, 0);
        repeat (3) @(negedge clk);
        check(wave_out == 1'b1, "R8", "output high after restarted window", wave_out, 1);

        // R10: decimal wraps.
        setup(3'd0, 1'b1, 1'b1);
        cnt_load = 1'b1; cnt_value = 16'h0000;
        @(negedge clk); cnt_load = 1'b0;
        @(negedge clk);
        check(count_now == 16'h9999, "R10", "decimal 0000 steps to 9999", count_now, 16'h9999);
        cnt_load = 1'b1; cnt_value = 16'h0100;
        @(negedge clk); cnt_load = 1'b0;
        @(negedge clk);
        check(count_now == 16'h0099, "R10", "decimal 0100 steps to 0099", count_now, 16'h0099);

        // R2: zero load is the longest binary period.
        run_vec('{3'd0, 1'b0, 16'd0, 17'd65537, 8'd0, 4'd2}, 70000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule